// File: doc/BRIEF.md
# BCD Time-of-Day Clock with Alarm

This block joins two 16-bit counter words into a 24-hour clock that counts in BCD. The hours/minutes word keeps the hours as two BCD digits in bits 15:8 and the minutes as two BCD digits in bits 7:0. The seconds word keeps the seconds as two BCD digits in bits 15:8 and a tenths-of-a-second digit in bits 7:4. Bits 3:0 of the seconds word hold a prescaler code. The code sets how many pulses of the input frequency `tick_in` make one tenth-of-a-second step.

Software presets the time by writing either word through a shared load bus. It reads the time by pulsing `save`. That copies both running words into hold registers on the same clock edge, so a read never shows half of a carry. Two 16-bit alarm registers feed equality comparators. While time-of-day mode is on, the hours/minutes alarm fires only when both words match their alarm registers.

A two-state controller sets whether the clock runs. In `ST_HALT` the words hold still and the prescaler stays cleared. In `ST_RUN` the prescaler counts pulses and advances the time. Transition `GO` (`ST_HALT` to `ST_RUN`) is taken on a clock edge where `tod_mode` is nonzero. Transition `STOP` (`ST_RUN` to `ST_HALT`) is taken on an edge where `tod_mode` is 2'b00. Both states stay put otherwise.

Top module: `tod_clock`

## Requirements
- R1: After reset, both time words, both hold registers and both alarm registers are 16'h0000. The controller is in `ST_HALT`, and `alarm1_out` and `alarm2_out` are low.
- R2: The time advances only while the controller is in `ST_RUN`, which it enters one edge after `tod_mode` becomes nonzero. With `tod_mode` at 2'b00, `tick_in` pulses leave both words unchanged.
- R3: Bits 3:0 of the seconds word select the divide ratio. Code 4'h5 makes one tenth step per 5 `tick_in` pulses and 4'h6 per 6 pulses. Code 4'hA and every other code give 10 pulses per step. The step is taken on the edge that samples the last pulse.
- R4: The tenths digit rolls from 9 to 0 and carries into the seconds. The seconds roll from 59 to 00 and carry into the minutes.
- R5: The minutes roll from 59 to 00 and carry into the hours. The hours roll from 23 to 00, so 23:59:59.9 steps to 00:00:00.0.
- R6: `load_hm` writes `load_data` into the hours/minutes word. `load_st` writes `load_data` into the seconds word, including the code, and restarts the prescaler count. A load wins over a step on the same edge.
- R7: On an edge with `save` high, both hold registers take the values both words had before that edge. The hold registers are unchanged on other edges.
- R8: `alarm1_out` is high exactly while `cmp_en[0]` is 1 and the seconds word equals alarm register 1. It stays high for as long as they remain equal.
- R9: With the controller in `ST_HALT`, `alarm2_out` is high while `cmp_en[1]` is 1 and the hours/minutes word equals alarm register 2. In `ST_RUN`, the seconds word must also equal alarm register 1, whatever the value of `cmp_en[0]`.
- R10: `alm1_wr` and `alm2_wr` write `alarm_data` into alarm register 1 and alarm register 2 respectively. The new value takes effect from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_in | input | 1 | One-cycle pulse of the input frequency |
| tod_mode | input | 2 | Time-of-day mode; 2'b00 is off, any other value runs the clock |
| cmp_en | input | 2 | Comparator enables: bit 0 for alarm 1, bit 1 for alarm 2 |
| load_hm | input | 1 | Write `load_data` into the hours/minutes word |
| load_st | input | 1 | Write `load_data` into the seconds word |
| load_data | input | 16 | Preset value |
| save | input | 1 | Copy both words into the hold registers |
| alm1_wr | input | 1 | Write alarm register 1 |
| alm2_wr | input | 1 | Write alarm register 2 |
| alarm_data | input | 16 | Alarm register write value |
| hold_hm | output | 16 | Saved hours/minutes word |
| hold_st | output | 16 | Saved seconds word |
| alarm1_out | output | 1 | Alarm 1 comparator output |
| alarm2_out | output | 1 | Alarm 2 comparator output |

## Verification
The rollover assertions assume every loaded digit is valid BCD within the range of its field (hours up to 23, minutes and seconds up to 59, tenths up to 9). They also assume a seconds word is loaded only while its prescaler code is either in use or about to be. The stimulus loads only such legal times and codes, and it changes inputs only on falling edges. Every step the bench expects comes from counting `tick_in` pulses against the loaded code. Each read goes through `save` and the hold registers.

// File: rtl/tod_pkg.sv
package tod_pkg;
    typedef enum logic {
        ST_HALT = 1'b0,
        ST_RUN  = 1'b1
    } tod_state_e;

    localparam int unsigned WORD_W  = 16;
    localparam int unsigned DIGIT_W = 4;
    localparam int unsigned CODE_W  = 4;

    localparam logic [CODE_W-1:0] CODE_DIV5  = 4'h5;
    localparam logic [CODE_W-1:0] CODE_DIV6  = 4'h6;
    localparam logic [CODE_W-1:0] CODE_DIV10 = 4'hA;
endpackage

// File: rtl/tod_prescaler.sv
module tod_prescaler #(
    parameter int unsigned CODE_W = 4,
    parameter int unsigned CNT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              restart,
    input  logic              tick,
    input  logic [CODE_W-1:0] code,
    output logic              step
);
    import tod_pkg::*;

    logic [CNT_W-1:0] pcnt;
    logic [CNT_W-1:0] div_last;

    // Terminal count is divisor minus one; unknown codes divide by ten.
    always_comb begin
        unique case (code)
            CODE_DIV5: div_last = CNT_W'(4);
            CODE_DIV6: div_last = CNT_W'(5);
            default:   div_last = CNT_W'(9);
        endcase
    end

    assign step = run && tick && (pcnt == div_last) && !restart;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pcnt <= '0;
        end else if (restart || !run) begin
            pcnt <= '0;
        end else if (tick) begin
            pcnt <= (pcnt == div_last) ? '0 : pcnt + CNT_W'(1);
        end
    end

    // R3: count never passes the terminal value of the code in use
    assert_pcnt_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !restart) |-> (pcnt <= div_last));

    // R2: no step unless running and fed a pulse
    assert_step_needs_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> (run && tick));
endmodule

// File: rtl/tod_time_chain.sv
module tod_time_chain #(
    parameter int unsigned WORD_W  = 16,
    parameter int unsigned DIGIT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  logic              load_hm,
    input  logic              load_st,
    input  logic [WORD_W-1:0] load_data,
    output logic [WORD_W-1:0] cnt_hm,
    output logic [WORD_W-1:0] cnt_st
);
    localparam logic [DIGIT_W-1:0] NINE = DIGIT_W'(9);
    localparam logic [DIGIT_W-1:0] FIVE = DIGIT_W'(5);
    localparam logic [DIGIT_W-1:0] TWO  = DIGIT_W'(2);
    localparam logic [DIGIT_W-1:0] THREE = DIGIT_W'(3);
    localparam logic [DIGIT_W-1:0] ONE  = DIGIT_W'(1);
    localparam logic [DIGIT_W-1:0] ZERO = '0;

    logic [DIGIT_W-1:0] d_t, d_s1, d_s10, d_m1, d_m10, d_h1, d_h10, d_code;
    logic [DIGIT_W-1:0] n_t, n_s1, n_s10, n_m1, n_m10, n_h1, n_h10;
    logic c_t, c_s1, c_s, c_m1, c_m, h_wrap;

    assign {d_s10, d_s1, d_t, d_code} = cnt_st;
    assign {d_h10, d_h1, d_m10, d_m1} = cnt_hm;

    always_comb begin
        c_t  = (d_t >= NINE);
        n_t  = c_t ? ZERO : d_t + ONE;
        c_s1 = c_t && (d_s1 >= NINE);
        n_s1 = c_t ? ((d_s1 >= NINE) ? ZERO : d_s1 + ONE) : d_s1;
        c_s  = c_s1 && (d_s10 >= FIVE);
        n_s10 = c_s1 ? ((d_s10 >= FIVE) ? ZERO : d_s10 + ONE) : d_s10;
        c_m1 = c_s && (d_m1 >= NINE);
        n_m1 = c_s ? ((d_m1 >= NINE) ? ZERO : d_m1 + ONE) : d_m1;
        c_m  = c_m1 && (d_m10 >= FIVE);
        n_m10 = c_m1 ? ((d_m10 >= FIVE) ? ZERO : d_m10 + ONE) : d_m10;
        h_wrap = (d_h10 >= TWO) && (d_h1 >= THREE);
        n_h10 = d_h10;
        n_h1  = d_h1;
        if (c_m) begin
            if (h_wrap) begin
                n_h10 = ZERO;
                n_h1  = ZERO;
            end else if (d_h1 >= NINE) begin
                n_h10 = d_h10 + ONE;
                n_h1  = ZERO;
            end else begin
                n_h1  = d_h1 + ONE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_hm <= '0;
            cnt_st <= '0;
        end else begin
            if (load_hm)   cnt_hm <= load_data;
            else if (step) cnt_hm <= {n_h10, n_h1, n_m10, n_m1};
            if (load_st)   cnt_st <= load_data;
            else if (step) cnt_st <= {n_s10, n_s1, n_t, d_code};
        end
    end

    // R5: midnight rollover clears every time digit
    assert_midnight_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load_hm && !load_st && cnt_hm == 16'h2359 && cnt_st[15:4] == 12'h599)
        |=> (cnt_hm == 16'h0000 && cnt_st[15:4] == 12'h000));

    // R4: tenths wrap to zero on a step from nine
    assert_tenths_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load_st && cnt_st[7:4] == 4'h9) |=> (cnt_st[7:4] == 4'h0));

    // R6: a load takes priority over any step
    assert_load_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
        load_st |=> (cnt_st == $past(load_data)));
endmodule

// File: rtl/tod_alarm.sv
module tod_alarm #(
    parameter int unsigned WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alm1_wr,
    input  logic              alm2_wr,
    input  logic [WORD_W-1:0] alarm_data,
    input  logic [1:0]        cmp_en,
    input  logic              tod_on,
    input  logic [WORD_W-1:0] cnt_hm,
    input  logic [WORD_W-1:0] cnt_st,
    output logic              alarm1_out,
    output logic              alarm2_out
);
    logic [WORD_W-1:0] alm1_q, alm2_q;
    logic eq1, eq2;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            alm1_q <= '0;
            alm2_q <= '0;
        end else begin
            if (alm1_wr) alm1_q <= alarm_data;
            if (alm2_wr) alm2_q <= alarm_data;
        end
    end

    assign eq1 = (cnt_st == alm1_q);
    assign eq2 = (cnt_hm == alm2_q);
    assign alarm1_out = cmp_en[0] && eq1;
    assign alarm2_out = cmp_en[1] && eq2 && (!tod_on || eq1);

    // R9: in time-of-day mode the second comparator needs the first word too
    assert_tod_joint_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (tod_on && alarm2_out) |-> (cnt_st == alm1_q && cnt_hm == alm2_q));

    // R10: a written alarm value is held from the next cycle
    assert_alarm_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        alm1_wr |=> (alm1_q == $past(alarm_data)));

    // R8: first alarm never fires with its comparator off
    assert_alarm1_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        alarm1_out |-> cmp_en[0]);
endmodule

// File: rtl/tod_clock.sv
module tod_clock
    import tod_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_in,
    input  logic [1:0]   tod_mode,
    input  logic [1:0]   cmp_en,
    input  logic         load_hm,
    input  logic         load_st,
    input  logic [W-1:0] load_data,
    input  logic         save,
    input  logic         alm1_wr,
    input  logic         alm2_wr,
    input  logic [W-1:0] alarm_data,
    output logic [W-1:0] hold_hm,
    output logic [W-1:0] hold_st,
    output logic         alarm1_out,
    output logic         alarm2_out
);
    localparam int unsigned CW = CODE_W;

    tod_state_e state, state_nx;
    logic run;
    logic step;
    logic [W-1:0] cnt_hm, cnt_st;

    // Next state: GO and STOP
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_HALT: if (tod_mode != 2'b00) state_nx = ST_RUN;
            ST_RUN:  if (tod_mode == 2'b00) state_nx = ST_HALT;
            default: state_nx = ST_HALT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_HALT;
        else        state <= state_nx;
    end

    // Outputs of the controller
    always_comb begin
        unique case (state)
            ST_RUN:  run = 1'b1;
            default: run = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_hm <= '0;
            hold_st <= '0;
        end else if (save) begin
            hold_hm <= cnt_hm;
            hold_st <= cnt_st;
        end
    end

    tod_prescaler #(.CODE_W(CW), .CNT_W(CW)) u_pre (
        .clk(clk), .rst_n(rst_n), .run(run), .restart(load_st),
        .tick(tick_in), .code(cnt_st[CW-1:0]), .step(step)
    );

    tod_time_chain #(.WORD_W(W), .DIGIT_W(DIGIT_W)) u_chain (
        .clk(clk), .rst_n(rst_n), .step(step), .load_hm(load_hm),
        .load_st(load_st), .load_data(load_data),
        .cnt_hm(cnt_hm), .cnt_st(cnt_st)
    );

    tod_alarm #(.WORD_W(W)) u_alarm (
        .clk(clk), .rst_n(rst_n), .alm1_wr(alm1_wr), .alm2_wr(alm2_wr),
        .alarm_data(alarm_data), .cmp_en(cmp_en), .tod_on(run),
        .cnt_hm(cnt_hm), .cnt_st(cnt_st),
        .alarm1_out(alarm1_out), .alarm2_out(alarm2_out)
    );

    // R7: both hold registers capture the same edge's words
    assert_save_coherent_R7: assert property (@(posedge clk) disable iff (!rst_n)
        save |=> (hold_hm == $past(cnt_hm) && hold_st == $past(cnt_st)));

    // R2: halted clock keeps its words still unless loaded
    assert_halt_still_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HALT && !load_hm && !load_st) |=> ($stable(cnt_hm) && $stable(cnt_st)));

    // R7: hold registers change only on save
    assert_hold_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !save |=> ($stable(hold_hm) && $stable(hold_st)));
endmodule

// File: tb/tb_tod_clock.sv
module tb_tod_clock;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_in = 1'b0;
    logic [1:0]  tod_mode = 2'b00;
    logic [1:0]  cmp_en = 2'b00;
    logic        load_hm = 1'b0, load_st = 1'b0;
    logic [15:0] load_data = '0;
    logic        save = 1'b0;
    logic        alm1_wr = 1'b0, alm2_wr = 1'b0;
    logic [15:0] alarm_data = '0;
    logic [15:0] hold_hm, hold_st;
    logic        alarm1_out, alarm2_out;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [15:0] q_hm[$];
    logic [15:0] q_st[$];
    string       q_tag[$];
    logic        save_d = 1'b0;

    always #10 clk = ~clk;

    tod_clock dut (
        .clk(clk), .rst_n(rst_n), .tick_in(tick_in), .tod_mode(tod_mode),
        .cmp_en(cmp_en), .load_hm(load_hm), .load_st(load_st),
        .load_data(load_data), .save(save), .alm1_wr(alm1_wr),
        .alm2_wr(alm2_wr), .alarm_data(alarm_data), .hold_hm(hold_hm),
        .hold_st(hold_st), .alarm1_out(alarm1_out), .alarm2_out(alarm2_out)
    );

    task automatic check(string req, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Monitor: compare hold registers one cycle after each save
    always @(posedge clk) save_d <= save;
    always @(negedge clk) begin
        if (save_d && q_hm.size() > 0) begin
            automatic logic [15:0] e_hm = q_hm.pop_front();
            automatic logic [15:0] e_st = q_st.pop_front();
            automatic string t = q_tag.pop_front();
            check({t, " hold_hm"}, hold_hm, e_hm);
            check({t, " hold_st"}, hold_st, e_st);
        end
    end

    // Driver tasks start and end just after a falling edge
    task automatic do_save(logic [15:0] e_hm, logic [15:0] e_st, string tag);
        q_hm.push_back(e_hm);
        q_st.push_back(e_st);
        q_tag.push_back(tag);
        save = 1'b1;
        @(negedge clk) save = 1'b0;
        @(negedge clk);
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) begin
            tick_in = 1'b1;
            @(negedge clk) tick_in = 1'b0;
            @(negedge clk);
        end
    endtask

    task automatic load(bit hm, logic [15:0] d);
        load_data = d;
        if (hm) load_hm = 1'b1; else load_st = 1'b1;
        @(negedge clk) begin load_hm = 1'b0; load_st = 1'b0; end
    endtask

    task automatic wr_alarm(bit second, logic [15:0] d);
        alarm_data = d;
        if (second) alm2_wr = 1'b1; else alm1_wr = 1'b1;
        @(negedge clk) begin alm1_wr = 1'b0; alm2_wr = 1'b0; end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check("R1 alarm1_out", {15'b0, alarm1_out}, 16'h0);
        check("R1 alarm2_out", {15'b0, alarm2_out}, 16'h0);
        check("R1 hold_hm", hold_hm, 16'h0);
        do_save(16'h0000, 16'h0000, "R1");

        // R2, R6: halted clock ignores pulses, loads still land
        load(1'b1, 16'h1234);
        load(1'b0, 16'h5905);
        ticks(20);
        do_save(16'h1234, 16'h5905, "R2");

        // R3: divide by five
        tod_mode = 2'b01;
        @(negedge clk);
        @(negedge clk);
        ticks(4);
        do_save(16'h1234, 16'h5905, "R3 div5 before");
        ticks(1);
        do_save(16'h1234, 16'h5915, "R3 div5 step");

        // R4, R5: carries through seconds and minutes into hours
        load(1'b1, 16'h1259);
        load(1'b0, 16'h5995);
        ticks(5);
        do_save(16'h1300, 16'h0005, "R4");

        // R5, R3: midnight with divide by six
        load(1'b1, 16'h2359);
        load(1'b0, 16'h5996);
        ticks(5);
        do_save(16'h2359, 16'h5996, "R3 div6 before");
        ticks(1);
        do_save(16'h0000, 16'h0006, "R5 midnight");

        // R3: code A and an unlisted code both divide by ten
        load(1'b0, 16'h000A);
        ticks(9);
        do_save(16'h0000, 16'h000A, "R3 divA before");
        ticks(1);
        do_save(16'h0000, 16'h001A, "R3 divA step");
        load(1'b0, 16'h0003);
        ticks(9);
        do_save(16'h0000, 16'h0003, "R3 other before");
        ticks(1);
        do_save(16'h0000, 16'h0013, "R3 other step");

        // R6: load on the stepping pulse wins and restarts the prescaler
        load(1'b0, 16'h0005);
        ticks(4);
        tick_in = 1'b1;
        load_st = 1'b1;
        load_data = 16'h4205;
        @(negedge clk) begin tick_in = 1'b0; load_st = 1'b0; end
        do_save(16'h0000, 16'h4205, "R6 priority");
        ticks(4);
        do_save(16'h0000, 16'h4205, "R6 restart before");
        ticks(1);
        do_save(16'h0000, 16'h4215, "R6 restart step");

        // R8, R9, R10: comparators with the clock halted
        tod_mode = 2'b00;
        @(negedge clk);
        load(1'b1, 16'h0830);
        load(1'b0, 16'h1505);
        wr_alarm(1'b0, 16'h1505);
        wr_alarm(1'b1, 16'h0830);
        check("R8 disabled a1", {15'b0, alarm1_out}, 16'h0);
        check("R9 disabled a2", {15'b0, alarm2_out}, 16'h0);
        cmp_en = 2'b01;
        @(negedge clk);
        check("R8 a1 match", {15'b0, alarm1_out}, 16'h1);
        check("R9 a2 off", {15'b0, alarm2_out}, 16'h0);
        cmp_en = 2'b11;
        @(negedge clk);
        check("R9 halt a2 match", {15'b0, alarm2_out}, 16'h1);
        check("R8 a1 still high", {15'b0, alarm1_out}, 16'h1);
        wr_alarm(1'b0, 16'h1605);
        check("R10 a1 after rewrite", {15'b0, alarm1_out}, 16'h0);
        check("R9 halt a2 alone", {15'b0, alarm2_out}, 16'h1);

        // R9: time-of-day mode needs both words to match
        tod_mode = 2'b10;
        @(negedge clk);
        check("R9 tod a2 needs both", {15'b0, alarm2_out}, 16'h0);
        cmp_en = 2'b10;
        wr_alarm(1'b0, 16'h1505);
        check("R9 tod a2 both", {15'b0, alarm2_out}, 16'h1);
        check("R8 a1 disabled", {15'b0, alarm1_out}, 16'h0);
        ticks(5);
        check("R9 tod a2 after step", {15'b0, alarm2_out}, 16'h0);
        do_save(16'h0830, 16'h1515, "R9 time");

        @(negedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule